// File: doc/BRIEF.md
# Fault Outcome Classifier

This block sits in a fault-injection bench next to two copies of one design: a copy that receives bit flips and an undisturbed golden copy, both fed the same input data on every cycle. When an injection is announced, the block watches the two copies' primary outputs for a fixed number of cycles. Over the same cycles it records whether the checker under study raised its detect flag or, in correction mode, its corrected flag. When the watch ends, the injection falls into exactly one outcome class, and a saturating counter for that class and a total-injections counter each advance by one.

From the counters the block presents the two terms of the coverage ratio, ready for a divider elsewhere. The numerator counts the good outcomes. The denominator is the total minus the silent outcomes, which were neither detected nor propagated. In detection mode four classes are used. In correction mode six are used, separating reports of "corrected" from reports of "uncorrectable".

A three-state machine runs the sequence. IDLE moves to OBSERVE when an injection is offered. OBSERVE stays put for WIN_LEN cycles, gathering sticky mismatch, detect and corrected flags, and moves to CLASSIFY after the last window cycle. CLASSIFY updates one class counter and the total, and always returns to IDLE on the next cycle.

Top module: `ofc_classifier`

## Requirements
- R1: After reset, `busy` is low and every class count, the total, `cov_num` and `cov_den` are zero.
- R2: `inj_valid` is accepted only on a cycle where `busy` is low. From the following cycle, `busy` stays high for exactly WIN_LEN+1 cycles. Any `inj_valid` seen while `busy` is high is ignored.
- R3: An injection counts as propagated when `faulty_out` differs from `golden_out` in any bit on any of the WIN_LEN cycles that follow the acceptance cycle. Differences on the acceptance cycle, on the classification cycle, or while idle have no effect.
- R4: In detection mode (`corr_mode`=0 at acceptance), a `det_flag` pulse on any window cycle marks the injection detected. The class index is then 0 for detected and propagated, 1 for detected only, 2 for propagated only, and 3 for neither. `corr_flag` is ignored in this mode.
- R5: In correction mode (`corr_mode`=1 at acceptance), the class index is set as follows:
  - `corr_flag` seen in the window gives 0 if propagated and 1 if not. A corrected report implies detection.
  - Otherwise, `det_flag` seen gives 4 if propagated and 5 if not.
  - Otherwise, the index is 2 if propagated and 3 if not.
- R6: Each injection raises exactly one class count and the total by one. The new counts appear on the cycle after `busy` falls, counting from the cycle in which `busy` was last high. Class i occupies `class_cnt[i*CNT_W +: CNT_W]`.
- R7: Every counter stops at 2^CNT_W-1 and holds there.
- R8: `clr` high at a clock edge zeroes all counters. It takes priority over a classification at the same edge.
- R9: `cov_den` equals the total minus class 3. `cov_num` follows the present value of `corr_mode`: with `corr_mode`=0 it is class 0 plus class 1, and with `corr_mode`=1 it is class 1 plus class 4 plus class 5.
- R10: The mode used for classification is the value of `corr_mode` on the acceptance cycle. Changes to `corr_mode` during the window have no effect on the class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of all counters |
| inj_valid | input | 1 | An injection happens on this cycle |
| corr_mode | input | 1 | 1 selects six-class correction mode |
| golden_out | input | DATA_W | Primary outputs of the fault-free copy |
| faulty_out | input | DATA_W | Primary outputs of the fault-injected copy |
| det_flag | input | 1 | Checker reports an error |
| corr_flag | input | 1 | Checker reports the error as corrected |
| busy | output | 1 | Observation or classification in progress |
| class_cnt | output | 6*CNT_W | Packed class counters, class i at bits i*CNT_W |
| total_cnt | output | CNT_W | Injections classified |
| cov_num | output | CNT_W+2 | Coverage numerator |
| cov_den | output | CNT_W | Coverage denominator |

## Verification
Injections are driven with single mismatch pulses and single flag pulses placed at the first and last window cycle, so the window edges are told apart from their neighbours. Mismatches placed on the acceptance and classification cycles check that those cycles lie outside the window. Every detect/corrected/mismatch combination is tried in both modes, including a corrected flag without a detect flag and a corrected flag in detection mode, so the two class maps cannot be confused. Further runs flip `corr_mode` during the window, hold `inj_valid` high through a whole window, raise `clr` on the classification cycle, and drive one class past its maximum.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    localparam int NUM_CLASSES = 6;
    localparam int CLS_W       = 3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_OBSERVE  = 2'd1,
        ST_CLASSIFY = 2'd2
    } ofc_state_e;

    // Outcome index from latched window flags.
    function automatic logic [CLS_W-1:0] ofc_class_of(
        input logic corr_mode,
        input logic det_seen,
        input logic corr_seen,
        input logic prop_seen
    );
        logic [CLS_W-1:0] idx;
        if (corr_mode && corr_seen)
            idx = prop_seen ? 3'd0 : 3'd1;
        else if (corr_mode && det_seen)
            idx = prop_seen ? 3'd4 : 3'd5;
        else if (!corr_mode && det_seen)
            idx = prop_seen ? 3'd0 : 3'd1;
        else
            idx = prop_seen ? 3'd2 : 3'd3;
        return idx;
    endfunction

endpackage

// File: rtl/ofc_sat_counter.sv
module ofc_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ofc_window_fsm.sv
module ofc_window_fsm
    import ofc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int WIN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inj_valid,
    input  logic              corr_mode,
    input  logic [DATA_W-1:0] golden_out,
    input  logic [DATA_W-1:0] faulty_out,
    input  logic              det_flag,
    input  logic              corr_flag,
    output logic              busy,
    output logic              cls_valid,
    output logic [CLS_W-1:0]  cls_idx
);
    localparam int WCW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WCW-1:0] WIN_LAST = WCW'(WIN_LEN - 1);

    ofc_state_e state_q, state_d;
    logic [WCW-1:0] win_q;
    logic prop_q, det_q, corr_q, mode_q;
    logic mismatch;

    assign mismatch = |(golden_out ^ faulty_out);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Window counter and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            prop_q <= 1'b0;
            det_q  <= 1'b0;
            corr_q <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (inj_valid) begin
                        win_q  <= '0;
                        prop_q <= 1'b0;
                        det_q  <= 1'b0;
                        corr_q <= 1'b0;
                        mode_q <= corr_mode;
                    end
                end
                ST_OBSERVE: begin
                    win_q  <= win_q + 1'b1;
                    prop_q <= prop_q | mismatch;
                    det_q  <= det_q | det_flag;
                    corr_q <= corr_q | corr_flag;
                end
                default: ;
            endcase
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        busy      = 1'b1;
        cls_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (inj_valid) state_d = ST_OBSERVE;
            end
            ST_OBSERVE: begin
                if (win_q == WIN_LAST) state_d = ST_CLASSIFY;
            end
            ST_CLASSIFY: begin
                cls_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        cls_idx = ofc_class_of(mode_q, det_q, corr_q, prop_q);
    end
endmodule

// File: rtl/ofc_classifier.sv
module ofc_classifier
    import ofc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int WIN_LEN = 4,
    parameter int CNT_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         inj_valid,
    input  logic                         corr_mode,
    input  logic [DATA_W-1:0]            golden_out,
    input  logic [DATA_W-1:0]            faulty_out,
    input  logic                         det_flag,
    input  logic                         corr_flag,
    output logic                         busy,
    output logic [NUM_CLASSES*CNT_W-1:0] class_cnt,
    output logic [CNT_W-1:0]             total_cnt,
    output logic [CNT_W+1:0]             cov_num,
    output logic [CNT_W-1:0]             cov_den
);
    localparam int SUM_W = CNT_W + 2;

    logic             cls_valid;
    logic [CLS_W-1:0] cls_idx;
    logic [CNT_W-1:0] cnt_arr [NUM_CLASSES];

    ofc_window_fsm #(.DATA_W(DATA_W), .WIN_LEN(WIN_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .inj_valid  (inj_valid),
        .corr_mode  (corr_mode),
        .golden_out (golden_out),
        .faulty_out (faulty_out),
        .det_flag   (det_flag),
        .corr_flag  (corr_flag),
        .busy       (busy),
        .cls_valid  (cls_valid),
        .cls_idx    (cls_idx)
    );

    for (genvar gi = 0; gi < NUM_CLASSES; gi++) begin : g_class
        logic hit;
        assign hit = cls_valid && (cls_idx == CLS_W'(gi));
        ofc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (hit),
            .cnt   (cnt_arr[gi])
        );
        assign class_cnt[gi*CNT_W +: CNT_W] = cnt_arr[gi];
    end

    ofc_sat_counter #(.CNT_W(CNT_W)) u_total (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (cls_valid),
        .cnt   (total_cnt)
    );

    always_comb begin
        if (corr_mode)
            cov_num = SUM_W'(cnt_arr[1]) + SUM_W'(cnt_arr[4]) + SUM_W'(cnt_arr[5]);
        else
            cov_num = SUM_W'(cnt_arr[0]) + SUM_W'(cnt_arr[1]);
        cov_den = total_cnt - cnt_arr[3];
    end
endmodule

// File: rtl/ofc_classifier_chk.sv
module ofc_classifier_chk #(
    parameter int WIN_LEN = 4,
    parameter int CNT_W   = 16,
    parameter int NCLS    = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clr,
    input logic                  inj_valid,
    input logic                  busy,
    input logic [NCLS*CNT_W-1:0] class_cnt,
    input logic [CNT_W-1:0]      total_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_run <= 0;
        else if (busy)
            busy_run <= busy_run + 1;
        else
            busy_run <= 0;
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && inj_valid) |=> busy);

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == WIN_LEN + 1));

    p_total_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(total_cnt) |-> ($past(busy) || $past(clr)));

    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (total_cnt - $past(total_cnt)) <= 1);

    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (total_cnt == CNT_MAX && !clr) |=> total_cnt == CNT_MAX);

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (total_cnt == '0 && class_cnt == '0));
endmodule

bind ofc_classifier ofc_classifier_chk #(
    .WIN_LEN (WIN_LEN),
    .CNT_W   (CNT_W),
    .NCLS    (ofc_pkg::NUM_CLASSES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .inj_valid (inj_valid),
    .busy      (busy),
    .class_cnt (class_cnt),
    .total_cnt (total_cnt)
);

// File: tb/test_ofc_classifier.sv
`timescale 1ns/1ps
module test_ofc_classifier;
    localparam int DW  = 8;
    localparam int WIN = 4;
    localparam int CW  = 5;
    localparam int MAXV = (1 << CW) - 1;
    localparam int WD_LIMIT = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic inj_valid = 1'b0;
    logic corr_mode = 1'b0;
    logic [DW-1:0] golden_out = 8'h5a;
    logic [DW-1:0] flip = '0;
    logic [DW-1:0] faulty_out;
    logic det_flag = 1'b0;
    logic corr_flag = 1'b0;
    logic busy;
    logic [6*CW-1:0] class_cnt;
    logic [CW-1:0] total_cnt;
    logic [CW+1:0] cov_num;
    logic [CW-1:0] cov_den;

    assign faulty_out = golden_out ^ flip;

    always #5 clk = ~clk;

    ofc_classifier #(.DATA_W(DW), .WIN_LEN(WIN), .CNT_W(CW)) i_ofc_classifier (
        .clk, .rst_n, .clr, .inj_valid, .corr_mode, .golden_out, .faulty_out,
        .det_flag, .corr_flag, .busy, .class_cnt, .total_cnt, .cov_num, .cov_den
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit done = 1'b0;
    int cycles = 0;

    // Behavioural reference model
    int m_cnt [6];
    int m_total = 0;
    int m_left = 0;
    bit m_commit = 0;
    bit m_prop, m_det, m_corr, m_mode;

    function automatic int ref_class(bit md, bit d, bit c, bit p);
        if (md) begin
            if (c) return p ? 0 : 1;
            if (d) return p ? 4 : 5;
        end else if (d) return p ? 0 : 1;
        return p ? 2 : 3;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) golden_out <= golden_out * 8'd5 + 8'd3;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_total = 0; m_left = 0; m_commit = 0;
        end else begin
            if (m_commit) begin
                int c;
                c = ref_class(m_mode, m_det, m_corr, m_prop);
                if (m_cnt[c] < MAXV) m_cnt[c]++;
                if (m_total < MAXV) m_total++;
                m_commit = 0;
            end else if (m_left > 0) begin
                if (golden_out != faulty_out) m_prop = 1;
                if (det_flag) m_det = 1;
                if (corr_flag) m_corr = 1;
                m_left--;
                if (m_left == 0) m_commit = 1;
            end else if (inj_valid) begin
                m_left = WIN; m_prop = 0; m_det = 0; m_corr = 0; m_mode = corr_mode;
            end
            if (clr) begin
                foreach (m_cnt[i]) m_cnt[i] = 0;
                m_total = 0;
            end
        end
    end

    // Per-cycle comparison, away from both clock edges
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            int en, ed;
            chk(cur_req, "busy", int'(busy), int'((m_left > 0) || m_commit));
            for (int i = 0; i < 6; i++)
                chk(cur_req, $sformatf("class%0d", i), int'(class_cnt[i*CW +: CW]), m_cnt[i]);
            chk(cur_req, "total", int'(total_cnt), m_total);
            en = corr_mode ? (m_cnt[1] + m_cnt[4] + m_cnt[5]) : (m_cnt[0] + m_cnt[1]);
            ed = m_total - m_cnt[3];
            chk(cur_req, "cov_num", int'(cov_num), en);
            chk(cur_req, "cov_den", int'(cov_den), ed);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // One injection; window slot indices run 0..WIN-1, -1 means never.
    task automatic inject(bit md, int mm_at, int det_at, int corr_at,
                          bit hold, bit edge_flip, bit toggle, bit clr_commit);
        @(negedge clk);
        inj_valid = 1; corr_mode = md;
        flip = edge_flip ? 8'h01 : 8'h00;
        @(negedge clk);
        if (!hold) inj_valid = 0;
        if (toggle) corr_mode = ~md;
        for (int i = 0; i < WIN; i++) begin
            flip = (i == mm_at) ? 8'h80 : 8'h00;
            det_flag = (i == det_at);
            corr_flag = (i == corr_at);
            @(negedge clk);
        end
        flip = edge_flip ? 8'h02 : 8'h00;
        det_flag = 0; corr_flag = 0;
        clr = clr_commit;
        @(negedge clk);
        inj_valid = 0; flip = 0; clr = 0; corr_mode = md;
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        @(negedge clk);
        chk("R1", "total after reset", int'(total_cnt), 0);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "cov_den after reset", int'(cov_den), 0);

        // Detection-mode classes and window edges
        cur_req = "R4";
        inject(0, -1, -1, -1, 0, 0, 0, 0);
        chk("R4", "silent to class3", int'(class_cnt[3*CW +: CW]), 1);
        inject(0, 2, -1, -1, 0, 0, 0, 0);
        inject(0, -1, 1, -1, 0, 0, 0, 0);
        inject(0, 0, 3, -1, 0, 0, 0, 0);
        inject(0, -1, -1, 2, 0, 0, 0, 0);
        chk("R4", "corr ignored in detect mode", int'(class_cnt[1*CW +: CW]), 1);
        cur_req = "R3";
        inject(0, WIN-1, WIN-1, -1, 0, 0, 0, 0);
        chk("R3", "last-slot mismatch into class0", int'(class_cnt[0]), 0);
        chk("R3", "class0 count", int'(class_cnt[0 +: CW]), 2);
        inject(0, -1, -1, -1, 0, 1, 0, 0);
        chk("R3", "edge mismatches ignored", int'(class_cnt[3*CW +: CW]), 3);

        // Correction-mode classes
        cur_req = "R5";
        do_clear();
        inject(1, 1, -1, 0, 0, 0, 0, 0);
        inject(1, -1, 2, 2, 0, 0, 0, 0);
        inject(1, -1, -1, -1, 0, 0, 0, 0);
        inject(1, 3, -1, -1, 0, 0, 0, 0);
        inject(1, 0, 0, -1, 0, 0, 0, 0);
        inject(1, -1, 3, -1, 0, 0, 0, 0);
        inject(1, -1, -1, 3, 0, 0, 0, 0);
        chk("R5", "class1 count", int'(class_cnt[1*CW +: CW]), 2);
        chk("R5", "class4 count", int'(class_cnt[4*CW +: CW]), 1);
        chk("R5", "class5 count", int'(class_cnt[5*CW +: CW]), 1);
        chk("R9", "corr numerator", int'(cov_num), 4);
        chk("R9", "corr denominator", int'(cov_den), 6);

        // Busy rules and held request
        cur_req = "R2";
        inject(0, -1, 0, -1, 1, 0, 0, 0);
        chk("R2", "held request counted once", int'(total_cnt), 8);

        // Mode latched at acceptance
        cur_req = "R10";
        inject(0, -1, 1, 1, 0, 0, 1, 0);
        inject(1, -1, 1, -1, 0, 0, 1, 0);

        // Clear priority
        cur_req = "R8";
        inject(0, 1, -1, -1, 0, 0, 0, 1);
        chk("R8", "clear beats classify", int'(total_cnt), 0);
        chk("R8", "class2 cleared", int'(class_cnt[2*CW +: CW]), 0);

        // Detection coverage terms
        cur_req = "R9";
        inject(0, 0, 0, -1, 0, 0, 0, 0);
        inject(0, -1, 0, -1, 0, 0, 0, 0);
        inject(0, -1, -1, -1, 0, 0, 0, 0);
        inject(0, 2, -1, -1, 0, 0, 0, 0);
        chk("R9", "detect numerator", int'(cov_num), 2);
        chk("R9", "detect denominator", int'(cov_den), 3);
        cur_req = "R6";
        inject(0, 1, -1, -1, 0, 0, 0, 0);
        chk("R6", "total step", int'(total_cnt), 5);

        // Saturation
        cur_req = "R7";
        do_clear();
        for (int k = 0; k < MAXV + 6; k++) inject(0, 1, -1, -1, 0, 0, 0, 0);
        chk("R7", "class2 saturated", int'(class_cnt[2*CW +: CW]), MAXV);
        chk("R7", "total saturated", int'(total_cnt), MAXV);

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule